// File: doc/BRIEF.md
# Random Number Generator Host Register Interface

This block is the host-facing side of a hardware random number generator. A sampler reads a bank of free-running oscillator bits at a programmable rate. A refill sequencer folds those samples into a 64-bit entropy pool and hands a fresh 64-bit word to software through two 32-bit output registers. Software starts the generator by setting an enable bit in the control register. It waits for the ready flag, either by polling the status register or through the level interrupt. It reads both halves of the word and then writes 1 to the clear register to release the next word.

After the startup phase the sequencer keeps refilling the pool. It can deliver a new word only once a minimum number of samples have been taken since the previous one. When the pool has been refilled by a maximum number of samples, sampling stops until the word is taken. A test mode shifts the raw sample stream into the pool with no feedback, so that the bit stream of a single selected oscillator can be inspected directly.

Top module: `rng_host_if`

## Requirements
- R1: Registers read back only their defined bits; all other bits read as 0.
  - Interrupt enable at 0x0C keeps bit 0.
  - Control at 0x14 keeps startup count in bits 31:16, enable in bit 10, and test-select bits 2 and 1.
  - Configuration at 0x18 keeps maximum-refill in bits 31:16, the sample divider in bits 11:8 and minimum-refill in bits 7:0.
  - The oscillator enable mask at 0x1C keeps bits 23:0.
- R2: Reads of the write-only clear register (0x10) and of any unmapped offset return 0. Writes to unmapped offsets and to read-only registers change nothing.
- R3: After the enable bit rises, status bit 0 (ready) sets after the startup sample count. That count is the startup field times 256 samples, and one sample is taken every divider+1 clock cycles.
- R4: A rising enable clears the pool. In normal mode each sample s is the XOR of the oscillator inputs selected by the mask. The pool shifts left by one with bit 0 becoming s XOR the old bit 63. The delivered word reads low half at 0x00 and high half at 0x04.
- R5: With control bits 10, 2 and 1 all set (test mode), each sample shifts into bit 0 unchanged, with no feedback.
- R6: The output registers read 0 while ready is clear. Reading them has no side effects: repeated reads return the same word and ready stays set.
- R7: Writing a value with bit 0 set to 0x10 clears ready. A write to 0x10 with bit 0 clear has no effect.
- R8: A new word is delivered after ready is cleared, but no earlier than the minimum-refill count of samples after the previous delivery. That count is the field times 64 samples; a field of 0 means the maximum-refill count.
- R9: After the maximum-refill count of samples (field times 256) following a delivery, sampling stops and the pool is frozen. A later clear delivers the frozen pool within a few cycles.
- R10: irq_o is high exactly when ready and interrupt enable bit 0 are both set, one cycle after both.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read strobe |
| osc_i | input | 24 | Free-running oscillator bits |
| irq_o | output | 1 | Level interrupt |

## Verification
The bench sweeps every word offset of the map after writing all ones. A design that decoded the wrong offset or kept undefined bits would read back nonzero where zero is due. Delivered words are compared against a pool model computed in the bench for both normal and test mode. A wrong feedback tap, a missing mask, or feedback left on in test mode changes the word. The bench times ready against the startup, minimum-refill and zero-encoded minimum windows, where a design that misscaled units or ignored the divider would deliver early or late. After waiting past the maximum refill, a clear must deliver at once the exact pool after startup plus maximum samples; a design that kept sampling would deliver a different word.

// File: rtl/rng_host_pkg.sv
package rng_host_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;
  localparam int POOL_W = 64;

  localparam logic [ADDR_W-1:0] OFS_OUT_LO = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_OUT_HI = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_STAT   = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_IEN    = 8'h0C;
  localparam logic [ADDR_W-1:0] OFS_CLR    = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_CTRL   = 8'h14;
  localparam logic [ADDR_W-1:0] OFS_CFG    = 8'h18;
  localparam logic [ADDR_W-1:0] OFS_MASK   = 8'h1C;

  typedef enum logic [1:0] {
    SQ_OFF   = 2'd0,
    SQ_START = 2'd1,
    SQ_RUN   = 2'd2,
    SQ_HOLD  = 2'd3
  } seq_state_t;
endpackage

// File: rtl/rng_sampler.sv
module rng_sampler #(
  parameter int NOSC  = 24,
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             active_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic [NOSC-1:0]  mask_i,
  input  logic [NOSC-1:0]  osc_i,
  output logic             tick_o,
  output logic             bit_o
);
  logic [NOSC-1:0]  cap_q;
  logic [DIV_W-1:0] dcnt_q;

  // one capture flop per oscillator, gated by its mask bit
  for (genvar g = 0; g < NOSC; g++) begin : g_cap
    always_ff @(posedge clk) begin
      if (rst) cap_q[g] <= 1'b0;
      else     cap_q[g] <= osc_i[g] & mask_i[g];
    end
  end

  assign bit_o  = ^cap_q;
  assign tick_o = active_i && (dcnt_q == div_i);

  always_ff @(posedge clk) begin
    if (rst || !active_i) dcnt_q <= '0;
    else if (tick_o)      dcnt_q <= '0;
    else                  dcnt_q <= dcnt_q + 1'b1;
  end
endmodule

// File: rtl/rng_refill_seq.sv
module rng_refill_seq
  import rng_host_pkg::*;
#(
  parameter int START_W   = 16,
  parameter int MIN_W     = 8,
  parameter int LONG_LG2  = 8,
  parameter int SHORT_LG2 = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en_i,
  input  logic               test_i,
  input  logic [START_W-1:0] startup_i,
  input  logic [START_W-1:0] maxr_i,
  input  logic [MIN_W-1:0]   minr_i,
  input  logic               tick_i,
  input  logic               bit_i,
  input  logic               clr_i,
  output logic               active_o,
  output logic               ready_o,
  output logic [POOL_W-1:0]  out_o
);
  localparam int CNT_W = START_W + LONG_LG2 + 1;
  localparam logic [CNT_W-1:0] FULL_N = CNT_W'(1) << (START_W + LONG_LG2);

  seq_state_t st_q;
  logic [CNT_W-1:0]  cnt_q, cnt_inc, start_n, max_n, min_raw, min_n;
  logic [POOL_W-1:0] pool_q, pool_nxt, out_q;
  logic ready_q, en_q, restart;

  assign start_n = (startup_i == '0) ? FULL_N
                 : ({{(CNT_W-START_W){1'b0}}, startup_i} << LONG_LG2);
  assign max_n   = (maxr_i == '0) ? FULL_N
                 : ({{(CNT_W-START_W){1'b0}}, maxr_i} << LONG_LG2);
  assign min_raw = (minr_i == '0) ? max_n
                 : ({{(CNT_W-MIN_W){1'b0}}, minr_i} << SHORT_LG2);
  assign min_n   = (min_raw > max_n) ? max_n : min_raw;
  assign cnt_inc = cnt_q + 1'b1;
  assign restart = en_i && !en_q;

  // feedback from the top bit only in normal mode
  assign pool_nxt = tick_i ? {pool_q[POOL_W-2:0], bit_i ^ (test_i ? 1'b0 : pool_q[POOL_W-1])}
                           : pool_q;

  assign active_o = (st_q == SQ_START) || (st_q == SQ_RUN);
  assign ready_o  = ready_q;
  assign out_o    = out_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= SQ_OFF;
      cnt_q   <= '0;
      pool_q  <= '0;
      out_q   <= '0;
      ready_q <= 1'b0;
      en_q    <= 1'b0;
    end else begin
      en_q <= en_i;
      if (clr_i) ready_q <= 1'b0;
      if (!en_i) begin
        st_q <= SQ_OFF;
      end else if (restart) begin
        st_q    <= SQ_START;
        pool_q  <= '0;
        cnt_q   <= '0;
        ready_q <= 1'b0;
      end else begin
        case (st_q)
          SQ_START: begin
            pool_q <= pool_nxt;
            if (tick_i) begin
              if (cnt_inc >= start_n) begin
                out_q   <= pool_nxt;
                ready_q <= 1'b1;
                cnt_q   <= '0;
                st_q    <= SQ_RUN;
              end else begin
                cnt_q <= cnt_inc;
              end
            end
          end
          SQ_RUN: begin
            pool_q <= pool_nxt;
            if (!ready_q && (cnt_q >= min_n)) begin
              out_q   <= pool_nxt;
              ready_q <= 1'b1;
              cnt_q   <= '0;
            end else if (tick_i) begin
              cnt_q <= cnt_inc;
              if (cnt_inc >= max_n) st_q <= SQ_HOLD;
            end
          end
          SQ_HOLD: begin
            if (!ready_q) begin
              out_q   <= pool_q;
              ready_q <= 1'b1;
              cnt_q   <= '0;
              st_q    <= SQ_RUN;
            end
          end
          default: st_q <= SQ_OFF;
        endcase
      end
    end
  end

  // R7: ready only drops through a clear or a fresh enable
  p_ready_kept_r7: assert property (@(posedge clk) disable iff (rst)
    (ready_q && !clr_i && !restart) |=> ready_q);
  // R6: delivered word is frozen while it is on offer
  p_out_frozen_r6: assert property (@(posedge clk) disable iff (rst)
    (ready_q && !clr_i) |=> $stable(out_q));
  // R9: no sampling once the pool is full
  p_hold_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    (st_q == SQ_HOLD) |-> !tick_i);
endmodule

// File: rtl/rng_busregs.sv
module rng_busregs
  import rng_host_pkg::*;
#(
  parameter int NOSC    = 24,
  parameter int START_W = 16,
  parameter int MIN_W   = 8,
  parameter int DIV_W   = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sel_i,
  input  logic               wr_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  rdata_o,
  input  logic               ready_i,
  input  logic [POOL_W-1:0]  out_i,
  output logic               en_o,
  output logic               test_o,
  output logic [START_W-1:0] startup_o,
  output logic [START_W-1:0] maxr_o,
  output logic [MIN_W-1:0]   minr_o,
  output logic [DIV_W-1:0]   div_o,
  output logic [NOSC-1:0]    mask_o,
  output logic               ien_o,
  output logic               clr_o
);
  logic [START_W-1:0] startup_q, maxr_q;
  logic [MIN_W-1:0]   minr_q;
  logic [DIV_W-1:0]   div_q;
  logic [NOSC-1:0]    mask_q;
  logic               en_q, tma_q, tmb_q, ien_q;
  logic [DATA_W-1:0]  rdata_q, ctrl_rd, cfg_rd;
  logic               wr_hit;

  assign wr_hit = sel_i && wr_i;
  assign clr_o  = wr_hit && (addr_i == OFS_CLR) && wdata_i[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      startup_q <= '0; maxr_q <= '0; minr_q <= '0; div_q <= '0;
      mask_q <= '0; en_q <= 1'b0; tma_q <= 1'b0; tmb_q <= 1'b0; ien_q <= 1'b0;
    end else if (wr_hit) begin
      case (addr_i)
        OFS_IEN:  ien_q <= wdata_i[0];
        OFS_CTRL: begin
          startup_q <= wdata_i[31:16];
          en_q      <= wdata_i[10];
          tmb_q     <= wdata_i[2];
          tma_q     <= wdata_i[1];
        end
        OFS_CFG: begin
          maxr_q <= wdata_i[31:16];
          div_q  <= wdata_i[8 +: DIV_W];
          minr_q <= wdata_i[0 +: MIN_W];
        end
        OFS_MASK: mask_q <= wdata_i[NOSC-1:0];
        default: ;
      endcase
    end
  end

  assign ctrl_rd = {startup_q, 5'b0, en_q, 7'b0, tmb_q, tma_q, 1'b0};
  assign cfg_rd  = {maxr_q, {(8-DIV_W){1'b0}}, div_q, {(8-MIN_W){1'b0}}, minr_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (sel_i && !wr_i) begin
      case (addr_i)
        OFS_OUT_LO: rdata_q <= ready_i ? out_i[31:0]  : '0;
        OFS_OUT_HI: rdata_q <= ready_i ? out_i[63:32] : '0;
        OFS_STAT:   rdata_q <= {31'b0, ready_i};
        OFS_IEN:    rdata_q <= {31'b0, ien_q};
        OFS_CTRL:   rdata_q <= ctrl_rd;
        OFS_CFG:    rdata_q <= cfg_rd;
        OFS_MASK:   rdata_q <= DATA_W'(mask_q);
        default:    rdata_q <= '0;
      endcase
    end
  end

  assign rdata_o   = rdata_q;
  assign en_o      = en_q;
  assign test_o    = en_q && tma_q && tmb_q;
  assign startup_o = startup_q;
  assign maxr_o    = maxr_q;
  assign minr_o    = minr_q;
  assign div_o     = div_q;
  assign mask_o    = mask_q;
  assign ien_o     = ien_q;

  // R1: configuration changes only through a bus write
  p_cfg_stable_r1: assert property (@(posedge clk) disable iff (rst)
    !wr_hit |=> ($stable(maxr_q) && $stable(minr_q) && $stable(div_q) && $stable(mask_q)));
endmodule

// File: rtl/rng_host_if.sv
module rng_host_if
  import rng_host_pkg::*;
#(
  parameter int NOSC      = 24,
  parameter int START_W   = 16,
  parameter int MIN_W     = 8,
  parameter int DIV_W     = 4,
  parameter int LONG_LG2  = 8,
  parameter int SHORT_LG2 = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NOSC-1:0]   osc_i,
  output logic              irq_o
);
  logic               en, test, ien, clr, ready, active, tick, sbit, irq_q;
  logic [START_W-1:0] startup, maxr;
  logic [MIN_W-1:0]   minr;
  logic [DIV_W-1:0]   div;
  logic [NOSC-1:0]    mask;
  logic [POOL_W-1:0]  word;

  rng_busregs #(.NOSC(NOSC), .START_W(START_W), .MIN_W(MIN_W), .DIV_W(DIV_W)) u_regs (
    .clk(clk), .rst(rst), .sel_i(bus_sel), .wr_i(bus_wr), .addr_i(bus_addr),
    .wdata_i(bus_wdata), .rdata_o(bus_rdata), .ready_i(ready), .out_i(word),
    .en_o(en), .test_o(test), .startup_o(startup), .maxr_o(maxr), .minr_o(minr),
    .div_o(div), .mask_o(mask), .ien_o(ien), .clr_o(clr)
  );

  rng_sampler #(.NOSC(NOSC), .DIV_W(DIV_W)) u_samp (
    .clk(clk), .rst(rst), .active_i(active), .div_i(div), .mask_i(mask),
    .osc_i(osc_i), .tick_o(tick), .bit_o(sbit)
  );

  rng_refill_seq #(.START_W(START_W), .MIN_W(MIN_W), .LONG_LG2(LONG_LG2),
                   .SHORT_LG2(SHORT_LG2)) u_seq (
    .clk(clk), .rst(rst), .en_i(en), .test_i(test), .startup_i(startup),
    .maxr_i(maxr), .minr_i(minr), .tick_i(tick), .bit_i(sbit), .clr_i(clr),
    .active_o(active), .ready_o(ready), .out_o(word)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= ready & ien;
  end
  assign irq_o = irq_q;

  // R10: interrupt only follows an enabled, ready word
  p_irq_source_r10: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> $past(ready && ien));
endmodule

// File: tb/sim_rng_host_if.sv
module sim_rng_host_if;
  localparam int CLK_PERIOD = 10;
  localparam int NOSC = 24;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NOSC-1:0] osc = '0;
  logic        irq;
  int tests = 0, fails = 0, cyc = 0;

  rng_host_if u0 (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .osc_i(osc), .irq_o(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_win(input string tag, input int v, input int lo, input int hi);
    tests++;
    if (v < lo || v > hi) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", tag, v, lo, hi);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 0; bus_addr = a;
    @(negedge clk); bus_sel = 0; d = bus_rdata;
  endtask

  task automatic rd_word(output logic [63:0] w);
    logic [31:0] lo, hi;
    rd(8'h00, lo); rd(8'h04, hi); w = {hi, lo};
  endtask

  task automatic wait_ready(input string tag, output int t);
    logic [31:0] d;
    t = -1;
    for (int i = 0; i < 20000; i++) begin
      rd(8'h08, d);
      if (d[0]) begin t = cyc; break; end
    end
    if (t < 0) check(tag, 64'd0, 64'd1);
  endtask

  // pool after n samples of constant bit s, from a cleared pool
  function automatic logic [63:0] pool_model(input int n, input bit s, input bit fb);
    logic [63:0] p = '0;
    for (int i = 0; i < n; i++) p = {p[62:0], s ^ (fb & p[63])};
    return p;
  endfunction

  function automatic logic [31:0] sweep_exp(input int a);
    case (a)
      8'h0C: return 32'h1;
      8'h14: return 32'hFFFF_0006;
      8'h18: return 32'hFFFF_0FFF;
      8'h1C: return 32'h00FF_FFFF;
      default: return 32'h0;
    endcase
  endfunction

  initial begin
    #(CLK_PERIOD * 100000);
    fails++; tests++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [63:0] w, w2;
    int t0, t1, t2;
    repeat (4) @(negedge clk);
    rst = 0;
    // reset state
    for (int a = 0; a <= 8'h20; a += 4) begin
      rd(8'(a), d); check($sformatf("R1 reset read %h", a), 64'(d), 64'd0);
    end
    check("R10 reset irq", 64'(irq), 64'd0);

    // R1/R2 sweep with all ones written, enable kept off
    wr(8'h0C, 32'hFFFF_FFFF);
    wr(8'h14, 32'hFFFF_FBFF);
    wr(8'h18, 32'hFFFF_FFFF);
    wr(8'h1C, 32'hFFFF_FFFF);
    wr(8'h08, 32'hFFFF_FFFF);
    wr(8'h10, 32'hFFFF_FFFE);
    wr(8'h24, 32'hFFFF_FFFF);
    wr(8'h3C, 32'h0);
    for (int a = 0; a <= 8'h3C; a += 4) begin
      rd(8'(a), d);
      check($sformatf("R1 R2 sweep %h", a), 64'(d), 64'(sweep_exp(a)));
    end
    wr(8'h0C, 32'h0);

    // R3/R4: normal mode, one oscillator at 1, divider 2
    osc = 24'h1; wr(8'h1C, 32'h1);
    wr(8'h18, (32'd1 << 16) | (32'd2 << 8) | 32'd1);
    wr(8'h14, (32'd1 << 16) | (32'd1 << 10));
    t0 = cyc;
    rd_word(w); check("R6 zero before ready", w, 64'd0);
    wait_ready("R3 startup ready", t1);
    check_win("R3 startup time", t1 - t0, 768 - 2, 768 + 10);
    rd_word(w); check("R4 normal word", w, pool_model(256, 1, 1));
    rd_word(w2); check("R6 reread same", w2, w);
    rd(8'h08, d); check("R6 ready kept after read", 64'(d), 64'd1);

    // R9: wait past max refill, then clear
    repeat (1000) @(negedge clk);
    wr(8'h10, 32'h0);
    rd(8'h08, d); check("R7 clear bit0=0 ignored", 64'(d), 64'd1);
    wr(8'h10, 32'h1);
    repeat (3) @(negedge clk);
    rd(8'h08, d); check("R9 immediate delivery", 64'(d), 64'd1);
    rd_word(w); check("R9 frozen pool word", w, pool_model(512, 1, 1));

    // R8: minimum refill 64 samples, divider 0
    wr(8'h14, 32'h0);
    wr(8'h18, (32'd2 << 16) | 32'd1);
    wr(8'h14, (32'd1 << 16) | (32'd1 << 10));
    wait_ready("R8 first", t1);
    wr(8'h10, 32'h1);
    rd(8'h08, d); check("R7 clear drops ready", 64'(d), 64'd0);
    rd_word(w); check("R6 zero after clear", w, 64'd0);
    wait_ready("R8 second", t2);
    check_win("R8 min refill 64", t2 - t1, 60, 72);

    // R8: minimum field 0 uses maximum refill (512)
    wr(8'h18, (32'd2 << 16));
    wr(8'h10, 32'h1);
    wait_ready("R8 zero-min", t1);
    wr(8'h10, 32'h1);
    wait_ready("R8 zero-min second", t2);
    check_win("R8 zero min = max", t2 - t1, 505, 520);

    // R4: mask excludes the active oscillator
    wr(8'h14, 32'h0);
    osc = 24'h2; wr(8'h1C, 32'h1);
    wr(8'h18, (32'd1 << 16) | 32'd1);
    wr(8'h14, (32'd1 << 16) | (32'd1 << 10));
    wait_ready("R4 masked", t1);
    rd_word(w); check("R4 masked osc ignored", w, 64'd0);

    // R5: test mode, s = 1 from oscillator 2 only
    wr(8'h14, 32'h0);
    osc = 24'h5; wr(8'h1C, 32'h4);
    wr(8'h14, (32'd1 << 16) | (32'd1 << 10) | 32'h6);
    wait_ready("R5 test ready", t1);
    rd_word(w); check("R5 raw ones", w, pool_model(256, 1, 0));
    // R4: two enabled oscillators cancel in normal mode
    wr(8'h14, 32'h0);
    wr(8'h1C, 32'h5);
    wr(8'h14, (32'd1 << 16) | (32'd1 << 10) | 32'h2);
    wait_ready("R4 xor ready", t1);
    rd_word(w); check("R4 xor of two ones", w, 64'd0);

    // R10: interrupt
    check("R10 irq off when disabled", 64'(irq), 64'd0);
    wr(8'h0C, 32'h1);
    @(negedge clk);
    check("R10 irq on", 64'(irq), 64'd1);
    wr(8'h10, 32'h1);
    @(negedge clk);
    check("R10 irq drops after clear", 64'(irq), 64'd0);
    wait_ready("R10 refill", t1);
    check("R10 irq back with ready", 64'(irq), 64'd1);
    wr(8'h0C, 32'h0);
    @(negedge clk);
    check("R10 irq masked", 64'(irq), 64'd0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule